// File: doc/BRIEF.md
# Serial EEPROM Page-Write Controller

This block is the byte-level write engine behind a two-wire serial EEPROM slave. A bit-level front end, not part of this block, turns the wire activity into three kinds of single-cycle events: a start condition, a stop condition, and a received byte. For each received byte the controller decides whether the slave acknowledges it. The controller checks the device-select byte, takes one word-address byte, and then collects any number of data bytes into a page buffer.

The page buffer is one page of 32 bytes. Inside it, the low five address bits advance and wrap. The upper address bits never change during a transfer. When a stop condition arrives, the controller starts a timed internal write cycle. At the end of that cycle it copies into the register-based storage array only those page slots that received a byte during the transfer.

While the write cycle runs, the controller ignores every bus event and acknowledges nothing. A master can therefore poll with a device-select byte until it is acknowledged again. The array has a separate combinational read port, which lets its contents be observed.

Top module: `eeprom_pw_ctrl`

## Requirements
- R1: After reset, `ack_o` and `busy_o` are 0 and every array location reads 0x00.
- R2: A device-select byte is acknowledged only when bits [7:4] equal `DEV_TYPE` (default 4'b1010) and bit 0 (direction) is 0. The acknowledge appears on `ack_o` as a one-cycle pulse, in the cycle after the byte event. Any other device-select byte gets no acknowledge, and every later byte is ignored until the next start.
- R3: After an accepted device-select byte, the next byte is acknowledged and loaded as the word address. Each data byte that follows is also acknowledged.
- R4: Each data byte goes to the current address. The low `PAGE_W` (5) address bits then increment by one, and the upper address bits stay unchanged.
- R5: If more than 32 data bytes arrive in one transfer, the low address bits wrap to the start of the same page. The later bytes replace the earlier ones, and the last byte written to a slot is the one committed.
- R6: A stop that follows at least one data byte raises `busy_o` on the next clock edge. `busy_o` stays high for exactly `WR_CYCLES` cycles. When it falls, the received bytes are readable from the array.
- R7: Only page slots that received a byte in the transfer are written. Every other location keeps its value.
- R8: While `busy_o` is high, start, stop and byte events have no effect and produce no acknowledge. This includes a matching device-select byte. After `busy_o` falls, a new transfer is accepted normally.
- R9: A start or stop that arrives before the word address has been received aborts the transfer without a write cycle. A start begins a fresh device-select phase.
- R10: Every start clears all page-slot valid flags. Data bytes received before a repeated start are therefore never committed. A stop that follows no data byte since the last start starts no write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start condition event (one cycle) |
| stop_i | input | 1 | Stop condition event (one cycle) |
| byte_valid_i | input | 1 | Received-byte event (one cycle) |
| byte_i | input | 8 | Received byte, valid with `byte_valid_i` |
| ack_o | output | 1 | Acknowledge decision, one cycle after the byte event |
| busy_o | output | 1 | Internal write cycle in progress |
| rd_addr_i | input | ADDR_W | Array read address |
| rd_data_o | output | 8 | Array contents at `rd_addr_i` (combinational) |

## Verification
The assertions are evaluated on every cycle. They cover four things: no acknowledge ever follows a busy cycle or a rejected device-select byte, each data byte moves the address one step inside its page, valid flags are empty after a start, and a write cycle ends only when the timer expires. Only the bench scenarios can show the contents of the array after a cycle. That includes wrap-around overwrites, slots left untouched, and data dropped by a repeated start or an abort. The exact length of the busy window is also visible only at the ports. For these, the bench sweeps every page with a different start offset and byte count and compares the whole array against an arithmetic model.

// File: rtl/eeprom_pw_pkg.sv
package eeprom_pw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_WADDR,
        ST_DATA,
        ST_IGNORE,
        ST_BUSY
    } pw_state_e;
endpackage

// File: rtl/pw_wr_timer.sv
module pw_wr_timer #(
    parameter int WR_CYCLES = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int CW = $clog2(WR_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WR_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (run_i && cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    end

    assign done_o = run_i && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> cnt_q <= LAST);
    p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> cnt_q == '0);
endmodule

// File: rtl/pw_page_buf.sv
module pw_page_buf #(
    parameter int PAGE_W = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr_i,
    input  logic                          we_i,
    input  logic [PAGE_W-1:0]             idx_i,
    input  logic [7:0]                    data_i,
    output logic [(1<<PAGE_W)-1:0][7:0]   data_o,
    output logic [(1<<PAGE_W)-1:0]        valid_o
);
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [PAGE_BYTES-1:0][7:0] data_d, data_q;
    logic [PAGE_BYTES-1:0]      valid_d, valid_q;

    always_comb begin
        data_d  = data_q;
        valid_d = valid_q;
        if (clr_i) begin
            valid_d = '0;
        end else if (we_i) begin
            data_d[idx_i]  = data_i;
            valid_d[idx_i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= '0;
        end else begin
            data_q  <= data_d;
            valid_q <= valid_d;
        end
    end

    assign data_o  = data_q;
    assign valid_o = valid_q;

    p_flags_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> valid_q == '0);
    p_slot_mark_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !clr_i) |=> valid_q[$past(idx_i)]);
endmodule

// File: rtl/pw_mem_array.sv
module pw_mem_array #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          commit_i,
    input  logic [ADDR_W-PAGE_W-1:0]      page_i,
    input  logic [(1<<PAGE_W)-1:0][7:0]   buf_i,
    input  logic [(1<<PAGE_W)-1:0]        valid_i,
    input  logic [ADDR_W-1:0]             raddr_i,
    output logic [7:0]                    rdata_o
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [DEPTH-1:0][7:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (commit_i) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (valid_i[i]) mem_d[{page_i, PAGE_W'(i)}] = buf_i[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign rdata_o = mem_q[raddr_i];

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> mem_q == $past(mem_q));
endmodule

// File: rtl/eeprom_pw_ctrl.sv
module eeprom_pw_ctrl
    import eeprom_pw_pkg::*;
#(
    parameter int         ADDR_W    = 8,
    parameter int         PAGE_W    = 5,
    parameter int         WR_CYCLES = 300,
    parameter logic [3:0] DEV_TYPE  = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              byte_valid_i,
    input  logic [7:0]        byte_i,
    output logic              ack_o,
    output logic              busy_o,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o
);
    localparam int HI_W       = ADDR_W - PAGE_W;
    localparam int PAGE_BYTES = 1 << PAGE_W;

    typedef struct packed {
        pw_state_e         state;
        logic [ADDR_W-1:0] addr;
        logic              ack;
    } ctrl_s;

    ctrl_s cur_q, nxt_d;

    logic                       buf_clr, buf_we, timer_done;
    logic [PAGE_BYTES-1:0][7:0] buf_data;
    logic [PAGE_BYTES-1:0]      buf_valid;

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.ack = 1'b0;
        buf_clr   = 1'b0;
        buf_we    = 1'b0;
        if (cur_q.state == ST_BUSY) begin
            if (timer_done) nxt_d.state = ST_IDLE;
        end else if (start_i) begin
            nxt_d.state = ST_DEV;
            buf_clr     = 1'b1;
        end else if (stop_i) begin
            nxt_d.state = (cur_q.state == ST_DATA && |buf_valid) ? ST_BUSY : ST_IDLE;
        end else if (byte_valid_i) begin
            unique case (cur_q.state)
                ST_DEV: begin
                    if (byte_i[7:4] == DEV_TYPE && !byte_i[0]) begin
                        nxt_d.state = ST_WADDR;
                        nxt_d.ack   = 1'b1;
                    end else begin
                        nxt_d.state = ST_IGNORE;
                    end
                end
                ST_WADDR: begin
                    nxt_d.addr  = byte_i[ADDR_W-1:0];
                    nxt_d.ack   = 1'b1;
                    nxt_d.state = ST_DATA;
                end
                ST_DATA: begin
                    buf_we     = 1'b1;
                    nxt_d.ack  = 1'b1;
                    nxt_d.addr = {cur_q.addr[ADDR_W-1:PAGE_W],
                                  cur_q.addr[PAGE_W-1:0] + 1'b1};
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state <= ST_IDLE;
            cur_q.addr  <= '0;
            cur_q.ack   <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign ack_o  = cur_q.ack;
    assign busy_o = (cur_q.state == ST_BUSY);

    pw_page_buf #(.PAGE_W(PAGE_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (buf_clr),
        .we_i    (buf_we),
        .idx_i   (cur_q.addr[PAGE_W-1:0]),
        .data_i  (byte_i),
        .data_o  (buf_data),
        .valid_o (buf_valid)
    );

    pw_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy_o),
        .done_o (timer_done)
    );

    pw_mem_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (timer_done),
        .page_i   (cur_q.addr[ADDR_W-1:PAGE_W]),
        .buf_i    (buf_data),
        .valid_i  (buf_valid),
        .raddr_i  (rd_addr_i),
        .rdata_o  (rd_data_o)
    );

    p_no_ack_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !ack_o);
    p_reject_dev_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_DEV && byte_valid_i && !start_i && !stop_i &&
         byte_i[7:4] != DEV_TYPE) |=> !ack_o);
    p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == ST_DATA && byte_valid_i && !start_i && !stop_i) |=>
        (cur_q.addr[ADDR_W-1:PAGE_W] == $past(cur_q.addr[ADDR_W-1:PAGE_W]) &&
         cur_q.addr[PAGE_W-1:0] == $past(cur_q.addr[PAGE_W-1:0]) + 1'b1));
    p_busy_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(timer_done));
    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((cur_q.state == ST_DEV || cur_q.state == ST_WADDR) && (start_i || stop_i))
        |=> !busy_o);
    p_hi_w_r4: assert property (@(posedge clk) disable iff (!rst_n)
        HI_W > 0);
endmodule

// File: tb/eeprom_pw_ctrl_tb.sv
module eeprom_pw_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;
    localparam int PAGE_W     = 5;
    localparam int WR_CYCLES  = 300;
    localparam int DEPTH      = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, stop_i = 1'b0, byte_valid_i = 1'b0;
    logic [7:0] byte_i = '0;
    logic ack_o, busy_o;
    logic [ADDR_W-1:0] rd_addr_i = '0;
    logic [7:0] rd_data_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_mem [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_pw_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .byte_valid_i(byte_valid_i), .byte_i(byte_i), .ack_o(ack_o), .busy_o(busy_o),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o));

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic ev_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic ev_stop();
        @(negedge clk) stop_i = 1'b1;
        @(negedge clk) stop_i = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, input int exp_ack, input string req);
        @(negedge clk) begin byte_valid_i = 1'b1; byte_i = b; end
        @(negedge clk) byte_valid_i = 1'b0;
        check(req, int'(ack_o), exp_ack);
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 37 + i * 13 + 5) ^ (i << 3));
    endfunction

    task automatic cmp_mem(input string req);
        for (int a = 0; a < DEPTH; a++) begin
            rd_addr_i = ADDR_W'(a);
            #1;
            check(req, int'(rd_data_o), int'(exp_mem[a]));
        end
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
    endtask

    task automatic page_write(input logic [7:0] wa, input int n, input int seed);
        int blen;
        ev_start();
        send(8'hA0, 1, "R2 device select ack");
        send(wa, 1, "R3 word address ack");
        for (int i = 0; i < n; i++) send(pat(seed, i), 1, "R3 data ack");
        ev_stop();
        check("R6 busy after stop", int'(busy_o), 1);
        blen = 0;
        while (busy_o) begin blen++; @(negedge clk); end
        check("R6 busy length", blen, WR_CYCLES);
        for (int i = 0; i < n; i++)
            exp_mem[{wa[7:5], 5'(int'(wa[4:0]) + i)}] = pat(seed, i);
        cmp_mem("R4 R5 R7 array contents");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) exp_mem[a] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ack after reset", int'(ack_o), 0);
        check("R1 busy after reset", int'(busy_o), 0);
        cmp_mem("R1 array reset");

        // single byte, full page, and wrap-around writes
        page_write(8'h45, 1, 11);
        page_write(8'h6A, 32, 12);
        page_write(8'h83, 40, 13);

        // sweep every page with its own offset and length
        for (int p = 0; p < 8; p++)
            page_write(8'((p << 5) | ((p * 3) & 31)), p * 5 + 1, 20 + p);

        // R8: polling and traffic during busy are ignored
        ev_start();
        send(8'hA0, 1, "R8 setup dev");
        send(8'h10, 1, "R8 setup addr");
        send(8'h77, 1, "R8 setup data");
        ev_stop();
        exp_mem[8'h10] = 8'h77;
        ev_start();
        send(8'hA0, 0, "R8 no ack to device select while busy");
        send(8'h11, 0, "R8 no ack to address while busy");
        send(8'h99, 0, "R8 no ack to data while busy");
        ev_stop();
        check("R8 still busy", int'(busy_o), 1);
        wait_idle();
        cmp_mem("R8 busy traffic ignored");
        page_write(8'h12, 2, 40);

        // R2: wrong device type and read direction
        ev_start();
        send(8'hB0, 0, "R2 wrong device type nack");
        send(8'h20, 0, "R2 later byte ignored");
        send(8'h55, 0, "R2 later byte ignored");
        ev_stop();
        check("R2 no write cycle", int'(busy_o), 0);
        ev_start();
        send(8'hA1, 0, "R2 read direction nack");
        send(8'h20, 0, "R2 later byte ignored");
        ev_stop();
        check("R2 no write cycle", int'(busy_o), 0);

        // R9: aborts before word address complete
        ev_start();
        send(8'hA0, 1, "R9 dev");
        ev_stop();
        check("R9 stop after dev no busy", int'(busy_o), 0);
        ev_start();
        ev_start();
        send(8'hA0, 1, "R9 restart dev accepted");
        ev_start();
        send(8'h30, 0, "R9 restart needs device select");

        // R10: stop with no data, and restart discards data
        ev_start();
        send(8'hA0, 1, "R10 dev");
        send(8'h30, 1, "R10 addr");
        ev_stop();
        check("R10 stop without data no busy", int'(busy_o), 0);
        ev_start();
        send(8'hA0, 1, "R10 dev");
        send(8'h30, 1, "R10 addr");
        send(8'hEE, 1, "R10 data before restart");
        send(8'hDD, 1, "R10 data before restart");
        ev_start();
        send(8'hA0, 1, "R10 dev again");
        send(8'h3A, 1, "R10 addr again");
        send(8'h5C, 1, "R10 data");
        ev_stop();
        wait_idle();
        exp_mem[8'h3A] = 8'h5C;
        cmp_mem("R10 discarded bytes not committed");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule